// File: doc/BRIEF.md
# Regenerative Daisy-Chain CRC Node

This block is the error-check engine of one stack device in a serial daisy chain. Each node sends its own data upstream together with the data of every node below it. It sends only one CRC word, not one CRC word per node. On each frame the node folds its own 16-bit word into a running CRC, high byte first. It then folds in every downstream data byte as it arrives. Once the expected number of bytes has been taken in, it presents that single regenerated CRC as valid.

A second accumulator runs alongside the first. It covers only the downstream data bytes and stops once the last of them has arrived. The two bytes that follow are the CRC word sent by the node below, and they are captured. They are compared once with this second CRC. A mismatch raises a sticky error flag. It also forces the two lowest bits of this node's outgoing word to ones, so the upstream host can see where the chain broke. The number of downstream bytes is twice the count of nodes below this one, so it follows from the chain length and the node position.

The controller has eight states. IDLE is the state after reset. OWN_HI and OWN_LO fold in the two bytes of the node's own word. DATA takes in downstream data. CRC_HI and CRC_LO capture the received CRC. CHECK compares it with the verification CRC. DONE holds the results. The transitions are:
- Start-of-frame in any state leads to OWN_HI.
- OWN_HI always leads to OWN_LO.
- OWN_LO leads to DONE when there is no downstream data, and to DATA otherwise.
- DATA leads to CRC_HI on the last expected data byte.
- CRC_HI leads to CRC_LO on an accepted byte.
- CRC_LO leads to CHECK on an accepted byte.
- CHECK always leads to DONE.
- DONE and IDLE stay put until the next start-of-frame.

Top module: `chain_crc_node`

## Requirements
- R1: Both CRCs use the generator x^16+x^15+x^2+1 (0x8005). They start at 0x0000, work MSB-first, have no final XOR and fold in one byte per clock.
- R2: `regen_crc` covers `own_word[15:8]`, then `own_word[7:0]`, then each downstream data byte in arrival order. The two received CRC bytes are not included. Idle cycles between strobes do not change the result.
- R3: `crc_valid` rises at the clock edge that folds in byte number 2 + 2*(`chain_len` − `node_pos`). Before that edge it is low. From that edge until the next `sof` it stays high, and `regen_crc` stays unchanged.
- R4: When `node_pos` >= `chain_len` the node is last. Its `crc_valid` is high from the third edge after the `sof` edge, its `regen_crc` is the CRC of `own_word` alone, and `crc_err` never rises.
- R5: The two accepted bytes that follow the downstream data are the received CRC, high byte first. At the edge after the low byte they are compared once with the CRC of the downstream data alone. A mismatch sets `crc_err`.
- R6: `crc_err` stays set until the next `sof`. While it is set, `marked_word` equals the word latched at `sof` with bits [1:0] = 2'b11. Otherwise `marked_word` equals that word unchanged.
- R7: `seg_valid` has no effect in the `sof` cycle, in the two cycles after it, and after the comparison (DONE).
- R8: `sof` in any state restarts the frame. At the next edge it clears `crc_valid`, `crc_err` and both CRCs.
- R9: After reset, `regen_crc`, `crc_valid`, `crc_err` and `marked_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse; latches the word, length and position |
| own_word | input | 16 | This node's data word |
| seg_valid | input | 1 | Strobe for a downstream byte |
| seg_data | input | 8 | Downstream byte (data, then CRC high, then CRC low) |
| chain_len | input | POS_W | Number of nodes in the chain |
| node_pos | input | POS_W | Position of this node, counted from 1 |
| regen_crc | output | 16 | Regenerated CRC sent upstream |
| crc_valid | output | 1 | `regen_crc` is complete |
| crc_err | output | 1 | The received downstream CRC did not match |
| marked_word | output | 16 | Outgoing data word, marked on error |

## Verification
The bench drives several kinds of frame:
- A last node with strobes held high during start-up. This tells a correct own-word-only CRC apart from one that absorbed the stray bytes.
- Upper and middle nodes with one and three downstream nodes, including idle gaps between strobes. These separate correct byte order and correct counting from off-by-one counts, a swapped own-byte order, and CRC bytes that leak into the regenerated CRC.
- A frame with one bit flipped in the received CRC. It is followed by strobes after DONE and by a restart part-way through a frame. Together these show that the error is sticky, that it marks the outgoing word, that late bytes are ignored, and that a restart clears everything.
- A position beyond the chain length, which must behave as a last node.

// File: rtl/chain_crc_pkg.sv
package chain_crc_pkg;
    localparam int CRC_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int LUT_DEPTH = 2 ** BYTE_W;
    localparam logic [CRC_W-1:0] GEN_POLY = 16'h8005;
    localparam logic [1:0]       ERR_MARK = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWN_HI,
        ST_OWN_LO,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_CHECK,
        ST_DONE
    } node_state_t;

    // Remainder of one byte placed at the top of the register, MSB-first
    function automatic logic [CRC_W-1:0] lut_entry(input logic [BYTE_W-1:0] idx);
        logic [CRC_W-1:0] r;
        r = {idx, {(CRC_W-BYTE_W){1'b0}}};
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ GEN_POLY;
            else            r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/crc_lut.sv
module crc_lut
    import chain_crc_pkg::*;
(
    input  logic [BYTE_W-1:0] idx,
    output logic [CRC_W-1:0]  val
);
    logic [CRC_W-1:0] tbl [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_ent
        assign tbl[g] = lut_entry(BYTE_W'(g));
    end

    assign val = tbl[idx];
endmodule

// File: rtl/crc_byte_acc.sv
module crc_byte_acc
    import chain_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);
    logic [BYTE_W-1:0] lut_idx;
    logic [CRC_W-1:0]  lut_val;
    logic [CRC_W-1:0]  crc_nxt;

    assign lut_idx = din ^ crc_q[CRC_W-1 -: BYTE_W];

    crc_lut u_lut (
        .idx (lut_idx),
        .val (lut_val)
    );

    assign crc_nxt = {crc_q[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ lut_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '0;
        else if (clr) crc_q <= '0;
        else if (en)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/node_ctrl.sv
module node_ctrl
    import chain_crc_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              seg_valid,
    input  logic [BYTE_W-1:0] seg_data,
    input  logic [CRC_W-1:0]  own_word,
    input  logic [POS_W-1:0]  chain_len,
    input  logic [POS_W-1:0]  node_pos,
    input  logic [CRC_W-1:0]  ver_crc,
    output logic              acc_clr,
    output logic              regen_en,
    output logic [BYTE_W-1:0] regen_din,
    output logic              ver_en,
    output logic              crc_valid,
    output logic              crc_err,
    output logic [CRC_W-1:0]  own_q
);
    localparam int CNT_W = POS_W + 2;

    node_state_t state, state_nxt;

    logic [CNT_W-1:0] ds_q;
    logic [CNT_W-1:0] ds_calc;
    logic [CNT_W-1:0] cnt_regen;
    logic [CNT_W-1:0] cnt_rx;
    logic [CRC_W-1:0] rx_crc_q;
    logic             rx_hi_ld, rx_lo_ld, cmp_now;

    // Downstream byte count: two per node below this one
    assign ds_calc = (node_pos >= chain_len) ? '0
                   : (CNT_W'(chain_len - node_pos) << 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state and strobes
    always_comb begin
        state_nxt = state;
        acc_clr   = sof;
        regen_en  = 1'b0;
        regen_din = seg_data;
        ver_en    = 1'b0;
        rx_hi_ld  = 1'b0;
        rx_lo_ld  = 1'b0;
        cmp_now   = 1'b0;
        if (sof) begin
            state_nxt = ST_OWN_HI;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_OWN_HI: begin
                    regen_en  = 1'b1;
                    regen_din = own_q[CRC_W-1 -: BYTE_W];
                    state_nxt = ST_OWN_LO;
                end
                ST_OWN_LO: begin
                    regen_en  = 1'b1;
                    regen_din = own_q[BYTE_W-1:0];
                    state_nxt = (ds_q == '0) ? ST_DONE : ST_DATA;
                end
                ST_DATA: begin
                    if (seg_valid) begin
                        regen_en = 1'b1;
                        ver_en   = 1'b1;
                        if (cnt_rx == ds_q - CNT_W'(1)) state_nxt = ST_CRC_HI;
                    end
                end
                ST_CRC_HI: begin
                    if (seg_valid) begin
                        rx_hi_ld  = 1'b1;
                        state_nxt = ST_CRC_LO;
                    end
                end
                ST_CRC_LO: begin
                    if (seg_valid) begin
                        rx_lo_ld  = 1'b1;
                        state_nxt = ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    cmp_now   = 1'b1;
                    state_nxt = ST_DONE;
                end
                ST_DONE: ;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // Frame registers, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q     <= '0;
            ds_q      <= '0;
            cnt_regen <= '0;
            cnt_rx    <= '0;
            rx_crc_q  <= '0;
            crc_valid <= 1'b0;
            crc_err   <= 1'b0;
        end else if (sof) begin
            own_q     <= own_word;
            ds_q      <= ds_calc;
            cnt_regen <= '0;
            cnt_rx    <= '0;
            rx_crc_q  <= '0;
            crc_valid <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            if (regen_en) begin
                cnt_regen <= cnt_regen + CNT_W'(1);
                if (cnt_regen + CNT_W'(1) == ds_q + CNT_W'(2)) crc_valid <= 1'b1;
            end
            if (ver_en)   cnt_rx <= cnt_rx + CNT_W'(1);
            if (rx_hi_ld) rx_crc_q[CRC_W-1 -: BYTE_W] <= seg_data;
            if (rx_lo_ld) rx_crc_q[BYTE_W-1:0]        <= seg_data;
            if (cmp_now && (rx_crc_q != ver_crc)) crc_err <= 1'b1;
        end
    end
endmodule

// File: rtl/chain_crc_node.sv
module chain_crc_node
    import chain_crc_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic [CRC_W-1:0]  own_word,
    input  logic              seg_valid,
    input  logic [BYTE_W-1:0] seg_data,
    input  logic [POS_W-1:0]  chain_len,
    input  logic [POS_W-1:0]  node_pos,
    output logic [CRC_W-1:0]  regen_crc,
    output logic              crc_valid,
    output logic              crc_err,
    output logic [CRC_W-1:0]  marked_word
);
    logic              acc_clr, regen_en, ver_en;
    logic [BYTE_W-1:0] regen_din;
    logic [CRC_W-1:0]  ver_crc;
    logic [CRC_W-1:0]  own_q;

    node_ctrl #(.POS_W(POS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .seg_valid (seg_valid),
        .seg_data  (seg_data),
        .own_word  (own_word),
        .chain_len (chain_len),
        .node_pos  (node_pos),
        .ver_crc   (ver_crc),
        .acc_clr   (acc_clr),
        .regen_en  (regen_en),
        .regen_din (regen_din),
        .ver_en    (ver_en),
        .crc_valid (crc_valid),
        .crc_err   (crc_err),
        .own_q     (own_q)
    );

    crc_byte_acc u_regen (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (regen_en),
        .din   (regen_din),
        .crc_q (regen_crc)
    );

    crc_byte_acc u_verify (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (ver_en),
        .din   (seg_data),
        .crc_q (ver_crc)
    );

    assign marked_word = crc_err ? {own_q[CRC_W-1:2], ERR_MARK} : own_q;
endmodule

// File: rtl/chain_crc_node_chk.sv
module chain_crc_node_chk
    import chain_crc_pkg::*;
#(
    parameter int POS_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof,
    input logic [CRC_W-1:0]  regen_crc,
    input logic              crc_valid,
    input logic              crc_err,
    input logic [CRC_W-1:0]  marked_word
);
    // R3
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid && !sof |=> crc_valid);

    // R3
    crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid && !sof |=> $stable(regen_crc));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err && !sof |=> crc_err);

    // R6
    err_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> marked_word[1:0] == ERR_MARK);

    // R8
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !crc_valid && !crc_err && regen_crc == '0);

    // R5
    err_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> crc_valid);
endmodule

bind chain_crc_node chain_crc_node_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .regen_crc   (regen_crc),
    .crc_valid   (crc_valid),
    .crc_err     (crc_err),
    .marked_word (marked_word)
);

// File: tb/chain_crc_node_tb.sv
module chain_crc_node_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int POS_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof = 1'b0;
    logic [15:0]      own_word = '0;
    logic             seg_valid = 1'b0;
    logic [7:0]       seg_data = '0;
    logic [POS_W-1:0] chain_len = '0;
    logic [POS_W-1:0] node_pos = '0;
    logic [15:0]      regen_crc;
    logic             crc_valid;
    logic             crc_err;
    logic [15:0]      marked_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] crc;
        logic        err;
        logic [15:0] word;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event frame_ev;

    always #2.5 clk = ~clk;

    chain_crc_node #(.POS_W(POS_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof         (sof),
        .own_word    (own_word),
        .seg_valid   (seg_valid),
        .seg_data    (seg_data),
        .chain_len   (chain_len),
        .node_pos    (node_pos),
        .regen_crc   (regen_crc),
        .crc_valid   (crc_valid),
        .crc_err     (crc_err),
        .marked_word (marked_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Bitwise reference of R1, independent of any table
    function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
        logic [15:0] c = '0;
        foreach (bytes[i]) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ bytes[i][b];
                c  = c << 1;
                if (fb) c = c ^ 16'h8005;
            end
        end
        return c;
    endfunction

    // Scoreboard monitor
    initial begin
        forever begin
            exp_t e;
            @(frame_ev);
            e = exp_q.pop_front();
            chk({"R2 regen_crc ", e.tag}, regen_crc, e.crc);
            chk({"R3 crc_valid ", e.tag}, 16'(crc_valid), 16'h1);
            chk({"R5 crc_err ", e.tag}, 16'(crc_err), 16'(e.err));
            chk({"R6 marked_word ", e.tag}, marked_word, e.word);
        end
    end

    task automatic run_frame(input int len, input int pos, input logic [15:0] own,
                             input logic [7:0] data[$], input bit bad, input bit stray,
                             input bit gaps, input string tag);
        logic [7:0]  all_b[$];
        logic [15:0] dn_crc;
        exp_t        e;
        all_b = {own[15:8], own[7:0]};
        foreach (data[i]) all_b.push_back(data[i]);
        dn_crc = ref_crc(data) ^ (bad ? 16'h0001 : 16'h0000);
        e.crc  = ref_crc(all_b);
        e.err  = bad && (data.size() > 0);
        e.word = e.err ? {own[15:2], 2'b11} : own;
        e.tag  = tag;
        exp_q.push_back(e);

        @(negedge clk);
        sof = 1'b1; own_word = own; chain_len = POS_W'(len); node_pos = POS_W'(pos);
        seg_valid = stray; seg_data = 8'h5A;
        @(negedge clk); sof = 1'b0;
        @(negedge clk);
        @(negedge clk); seg_valid = 1'b0;
        // R4: a last node is complete after the third edge; R3: others not yet
        chk({"R3/R4 early valid ", tag}, 16'(crc_valid), 16'(data.size() == 0));
        foreach (data[i]) begin
            seg_valid = 1'b1; seg_data = data[i];
            @(negedge clk);
            chk({"R3 valid timing ", tag}, 16'(crc_valid), 16'(i == data.size() - 1));
            if (gaps) begin
                seg_valid = 1'b0; seg_data = 8'hC3;
                @(negedge clk);
            end
        end
        if (data.size() > 0) begin
            seg_valid = 1'b1; seg_data = dn_crc[15:8];
            @(negedge clk); seg_data = dn_crc[7:0];
            @(negedge clk); seg_valid = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        -> frame_ev;
        #0.1;
    endtask

    initial begin
        logic [7:0] d3[$];
        logic [7:0] d1[$];
        logic [7:0] none[$];
        logic [15:0] keep_crc;
        d3 = {8'hA5, 8'h20, 8'hA5, 8'h30, 8'hA5, 8'h40};
        d1 = {8'h3C, 8'h96};
        none = {};

        // R9 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 regen_crc", regen_crc, 16'h0000);
        chk("R9 crc_valid", 16'(crc_valid), 16'h0);
        chk("R9 crc_err", 16'(crc_err), 16'h0);
        chk("R9 marked_word", marked_word, 16'h0000);

        // R4 + R7: last node with stray strobes in the start-up cycles
        run_frame(4, 4, 16'hA540, none, 1'b0, 1'b1, 1'b0, "last node");
        // R1/R2/R3/R5: top node, three downstream nodes, with gaps
        run_frame(4, 1, 16'hA510, d3, 1'b0, 1'b0, 1'b1, "pos1 good");
        // R2: one downstream node, back-to-back bytes
        run_frame(4, 3, 16'h1234, d1, 1'b0, 1'b0, 1'b0, "pos3 good");
        // R5/R6: corrupted downstream CRC
        run_frame(4, 1, 16'hA510, d3, 1'b1, 1'b0, 1'b0, "pos1 bad");

        // R6 persistence and R7 strobes after DONE
        keep_crc = regen_crc;
        @(negedge clk); seg_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            seg_data = 8'(8'h11 * (i + 1));
            @(negedge clk);
        end
        seg_valid = 1'b0;
        @(negedge clk);
        chk("R7 regen after DONE", regen_crc, keep_crc);
        chk("R6 err persists", 16'(crc_err), 16'h1);
        chk("R6 mark persists", marked_word, 16'hA513);

        // R8 restart part-way through a frame
        sof = 1'b1; own_word = 16'hBEEF; chain_len = 9'd4; node_pos = 9'd2;
        @(negedge clk); sof = 1'b0;
        chk("R8 err cleared", 16'(crc_err), 16'h0);
        chk("R8 valid cleared", 16'(crc_valid), 16'h0);
        chk("R8 crc cleared", regen_crc, 16'h0000);
        repeat (2) @(negedge clk);
        seg_valid = 1'b1; seg_data = 8'h77;
        repeat (3) @(negedge clk);
        seg_valid = 1'b0;
        run_frame(4, 2, 16'hBEEF, {8'h01, 8'h02, 8'h03, 8'h04}, 1'b0, 1'b0, 1'b1, "pos2 restart");

        // R4: position beyond length acts as last node
        run_frame(3, 5, 16'h0F0F, none, 1'b1, 1'b1, 1'b0, "pos past len");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule